// File: doc/BRIEF.md
# Interleaved-Slot 6-bit PWM Bank

A set of 6-bit pulse-width modulators for the tuning-voltage and level controls of a television controller. All channels share one frame of 64 equal slots, timed by a slot clock that is the system clock divided by a prescaler. Each duty bit does not extend one long pulse. It switches on its own set of slots spread evenly across the frame. After low-pass filtering the average level is unchanged, but the ripple sits at a far higher frequency than a single compare would give.

Software writes a channel's duty code together with an output-select bit through a simple write port. The duty code is held in a staging register and copied into the channel's working register only as the frame wraps to slot 0. A frame therefore never carries two different duty values. When the output-select bit is clear, the pin carries the ordinary port value instead of the modulator. A pin stays undriven from reset until its channel is first written.

Top module: `bitspread_pwm_bank`

## Requirements
- R1: While reset is held and in the cycle after it is released, every `pin_oe` bit is 0, every `pin_out` bit is 0 and the slot counter is at slot 0.
- R2: Each slot lasts PRESC clock cycles, and a frame is 64 slots (64*PRESC cycles) starting at slot 0. The first clock edge after reset release is cycle 1. The output sampled after edge n shows slot ((n-1)/PRESC) mod 64, so slot 32 of a frame appears 32*PRESC cycles into that frame.
- R3: For a slot s other than 0, let k be the position of the lowest set bit of s. The channel output for that slot is high exactly when duty bit 5-k is set. Duty bit 5 owns the odd slots; bit 0 owns slot 32 only.
- R4: The number of high slots in a frame equals the 6-bit duty code, from 0 for code 0 up to 63 for code 63. A frame is never high for all 64 slots.
- R5: Slot 0 is low for every duty code on every channel whose output select is set.
- R6: A duty code written during a frame has no effect on that frame. It is used from slot 0 of the next frame onward.
- R7: A write made in the clock cycle in which the frame wraps from slot 63 to slot 0 is used for the frame that starts in that same cycle.
- R8: A write carries `wr_ch` (channel index), `wr_duty` and `wr_pwm_sel`, and the select applies from the next cycle. With the select at 0, `pin_out` of that channel equals the `port_dout` bit sampled one clock earlier. With the select at 1, it carries the modulator.
- R9: A channel's `pin_oe` rises in the cycle after its first write and then stays high. A write to one channel changes neither the output enable nor the waveform of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one channel |
| wr_ch | input | CH_W | Index of the channel being written |
| wr_duty | input | 6 | Duty code, high slots per frame |
| wr_pwm_sel | input | 1 | 1 routes the modulator to the pin, 0 routes the port value |
| port_dout | input | NCH | Ordinary port values used when the select is 0 |
| pin_out | output | NCH | Registered pin values |
| pin_oe | output | NCH | Pin drive enables, low until the channel is first written |

## Verification
The functions that can land on the same edge are a software write and the frame-boundary copy from staging to working register. The bench waits until the cycle count sits one edge before a frame wrap. It then issues a write on exactly the wrapping edge and checks that the whole following frame carries the new code's slot pattern and high-slot count. A second write is placed in the middle of a frame, and the bench checks that the rest of that frame still follows the old code slot by slot.

// File: rtl/bsp_pkg.sv
`timescale 1ns/1ps
package bsp_pkg;
  // Slot index and duty code share one width: 2**SLOT_BITS slots per frame.
  localparam int unsigned SLOT_BITS = 6;
  localparam int unsigned NUM_SLOTS = 1 << SLOT_BITS;

  typedef logic [SLOT_BITS-1:0] slot_t;
endpackage

// File: rtl/bsp_timebase.sv
`timescale 1ns/1ps
module bsp_timebase
  import bsp_pkg::*;
#(
  parameter int unsigned PRESC = 4
) (
  input  logic  clk,
  input  logic  rst,
  output slot_t slot_idx,
  output logic  slot_tick,
  output logic  frame_wrap
);
  generate
    if (PRESC <= 1) begin : g_nodiv
      assign slot_tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PC_W = $clog2(PRESC);
      localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESC - 1);
      logic [PC_W-1:0] pc;

      always_ff @(posedge clk) begin
        if (rst) begin
          pc <= '0;
        end else if (pc == PC_LAST) begin
          pc <= '0;
        end else begin
          pc <= pc + 1'b1;
        end
      end

      assign slot_tick = (pc == PC_LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_idx <= '0;
    end else if (slot_tick) begin
      slot_idx <= slot_idx + 1'b1;
    end
  end

  // Last clock of slot 63: the next edge starts a new frame.
  assign frame_wrap = slot_tick && (slot_idx == '1);
endmodule

// File: rtl/bsp_chan_regs.sv
`timescale 1ns/1ps
module bsp_chan_regs
  import bsp_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CH_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [CH_W-1:0]       wr_ch,
  input  slot_t                 wr_duty,
  input  logic                  wr_pwm_sel,
  input  logic                  frame_wrap,
  output logic [NCH-1:0][SLOT_BITS-1:0] act_duty,
  output logic [NCH-1:0]        sel_q,
  output logic [NCH-1:0]        cfg_q
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    slot_t pend_q;
    logic  hit;

    assign hit = wr_en && (wr_ch == CH_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q      <= '0;
        act_duty[i] <= '0;
        sel_q[i]    <= 1'b0;
        cfg_q[i]    <= 1'b0;
      end else begin
        if (hit) begin
          pend_q   <= wr_duty;
          sel_q[i] <= wr_pwm_sel;
          cfg_q[i] <= 1'b1;
        end
        // Working copy changes only as the frame wraps; a write on that
        // same edge is forwarded so it is not held back a whole frame.
        if (frame_wrap) begin
          act_duty[i] <= hit ? wr_duty : pend_q;
        end
      end
    end
  end
endmodule

// File: rtl/bsp_slot_weight.sv
`timescale 1ns/1ps
module bsp_slot_weight
  import bsp_pkg::*;
(
  input  slot_t slot_idx,
  input  slot_t duty,
  output logic  on
);
  // A slot belongs to the duty bit selected by its lowest set bit:
  // lowest set bit at position k -> duty bit (SLOT_BITS-1-k).
  logic [SLOT_BITS-1:0] hit;

  for (genvar k = 0; k < SLOT_BITS; k++) begin : g_w
    if (k == 0) begin : g_lsb
      assign hit[k] = slot_idx[0] && duty[SLOT_BITS-1];
    end else begin : g_up
      assign hit[k] = slot_idx[k] && (slot_idx[k-1:0] == '0)
                      && duty[SLOT_BITS-1-k];
    end
  end

  assign on = |hit;
endmodule

// File: rtl/bitspread_pwm_bank.sv
`timescale 1ns/1ps
module bitspread_pwm_bank
  import bsp_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned PRESC = 4,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [5:0]      wr_duty,
  input  logic            wr_pwm_sel,
  input  logic [NCH-1:0]  port_dout,
  output logic [NCH-1:0]  pin_out,
  output logic [NCH-1:0]  pin_oe
);
  slot_t                         slot_idx;
  logic                          slot_tick;
  logic                          frame_wrap;
  logic [NCH-1:0][SLOT_BITS-1:0] act_q;
  logic [NCH-1:0]                sel_q;
  logic [NCH-1:0]                cfg_q;
  logic [NCH-1:0]                pwm_on;

  bsp_timebase #(.PRESC(PRESC)) u_tb (
    .clk        (clk),
    .rst        (rst),
    .slot_idx   (slot_idx),
    .slot_tick  (slot_tick),
    .frame_wrap (frame_wrap)
  );

  bsp_chan_regs #(.NCH(NCH), .CH_W(CH_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_ch      (wr_ch),
    .wr_duty    (wr_duty),
    .wr_pwm_sel (wr_pwm_sel),
    .frame_wrap (frame_wrap),
    .act_duty   (act_q),
    .sel_q      (sel_q),
    .cfg_q      (cfg_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_out
    bsp_slot_weight u_w (
      .slot_idx (slot_idx),
      .duty     (act_q[i]),
      .on       (pwm_on[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= 1'b0;
      end else begin
        pin_out[i] <= sel_q[i] ? pwm_on[i] : port_dout[i];
        pin_oe[i]  <= cfg_q[i];
      end
    end
  end
endmodule

// File: rtl/bitspread_pwm_checker.sv
`timescale 1ns/1ps
module bitspread_pwm_checker
  import bsp_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input logic                   clk,
  input logic                   rst,
  input slot_t                  slot_idx,
  input logic                   slot_tick,
  input logic [NCH-1:0]         sel_q,
  input logic [NCH*SLOT_BITS-1:0] act_flat,
  input logic [NCH-1:0]         pin_out,
  input logic [NCH-1:0]         pin_oe
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && slot_idx == '0));

  a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
    slot_tick |=> (slot_idx == slot_t'($past(slot_idx) + 1'b1)));

  a_r2_slot_hold: assert property (@(posedge clk) disable iff (rst)
    !slot_tick |=> $stable(slot_idx));

  a_r5_slot0_low: assert property (@(posedge clk) disable iff (rst)
    (slot_idx == '0) |=> ((pin_out & $past(sel_q)) == '0));

  a_r6_duty_frozen: assert property (@(posedge clk) disable iff (rst)
    !(slot_tick && slot_idx == '1) |=> $stable(act_flat));

  a_r9_oe_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_oe & $past(pin_oe)) == $past(pin_oe)));
endmodule

bind bitspread_pwm_bank bitspread_pwm_checker #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .slot_idx  (slot_idx),
  .slot_tick (slot_tick),
  .sel_q     (sel_q),
  .act_flat  (act_q),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/tb_bitspread_pwm_bank.sv
`timescale 1ns/1ps
module tb_bitspread_pwm_bank;
  localparam int NCH   = 8;
  localparam int PRESC = 4;
  localparam int FRAME = 64 * PRESC;
  localparam int NV    = 6;
  localparam logic [5:0] T_DUTY [NV] = '{6'd0, 6'd1, 6'd32, 6'd63, 6'd21, 6'd42};
  localparam int         T_EXP  [NV] = '{0, 1, 32, 63, 21, 42};

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [2:0]     wr_ch = '0;
  logic [5:0]     wr_duty = '0;
  logic           wr_pwm_sel = 1'b0;
  logic [NCH-1:0] port_dout = '0;
  logic [NCH-1:0] pin_out;
  logic [NCH-1:0] pin_oe;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  bitspread_pwm_bank #(.NCH(NCH), .PRESC(PRESC)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_duty(wr_duty),
    .wr_pwm_sel(wr_pwm_sel), .port_dout(port_dout), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  function automatic logic ref_on(input logic [5:0] d, input int s);
    if (s == 0) return 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (s[k]) return d[5-k];
    end
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [5:0] d, input logic sel);
    wr_en = 1'b1; wr_ch = 3'(ch); wr_duty = d; wr_pwm_sel = sel;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic align(input int m);
    while ((cyc % FRAME) != m) @(negedge clk);
  endtask

  task automatic measure(input int ch, input logic [5:0] d, input int n,
                         output int highs, output int bad, output int s0hi,
                         output int first);
    highs = 0; bad = 0; s0hi = 0; first = -1;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      begin
        int s;
        s = ((cyc - 1) / PRESC) % 64;
        if (pin_out[ch] !== ref_on(d, s)) bad++;
        if (pin_out[ch] === 1'b1) begin
          highs++;
          if (s == 0) s0hi++;
          if (first < 0) first = (cyc - 1) % FRAME;
        end
      end
    end
  endtask

  task automatic frame_check(input int ch, input logic [5:0] d, input int exp,
                             output int first);
    int h, b, z;
    align(0);
    measure(ch, d, FRAME, h, b, z, first);
    check(b == 0, "R3 slot map", b, 0);
    check(h / PRESC == exp, "R4 high slots", h / PRESC, exp);
    check(z == 0, "R5 slot0", z, 0);
  endtask

  initial begin
    int h, b, z, f;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(pin_oe == '0, "R1 oe", int'(pin_oe), 0);
    check(pin_out == '0, "R1 out", int'(pin_out), 0);
    repeat (5) @(negedge clk);
    check(pin_oe == '0, "R9 oe before write", int'(pin_oe), 0);

    for (int i = 0; i < NV; i++) begin
      wr(i, T_DUTY[i], 1'b1);
      frame_check(i, T_DUTY[i], T_EXP[i], f);
      if (i == 1) check(f == 32 * PRESC, "R2 slot32 position", f, 32 * PRESC);
    end

    // R6: mid-frame write leaves the running frame untouched
    align(100);
    wr(0, 6'd45, 1'b1);
    measure(0, 6'd0, FRAME - 101, h, b, z, f);
    check(b == 0 && h == 0, "R6 old frame kept", h, 0);
    frame_check(0, 6'd45, 45, f);

    // R7: write on the wrapping edge takes the new frame
    align(FRAME - 1);
    wr(2, 6'd7, 1'b1);
    measure(2, 6'd7, FRAME, h, b, z, f);
    check(b == 0, "R7 slot map", b, 0);
    check(h / PRESC == 7, "R7 high slots", h / PRESC, 7);

    // R8: select clear passes port value with one clock delay
    wr(6, 6'd9, 1'b0);
    port_dout[6] = 1'b1;
    @(negedge clk);
    check(pin_out[6] === 1'b1, "R8 port high", int'(pin_out[6]), 1);
    port_dout[6] = 1'b0;
    @(negedge clk);
    check(pin_out[6] === 1'b0, "R8 port low", int'(pin_out[6]), 0);

    // R9: enables per channel, other channels undisturbed
    check(pin_oe[6] === 1'b1, "R9 oe written", int'(pin_oe[6]), 1);
    check(pin_oe[7] === 1'b0, "R9 oe unwritten", int'(pin_oe[7]), 0);
    frame_check(3, 6'd63, 63, f);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule